// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds a set of 32-bit configuration words in two copies. Register bus writes only change the pending copy, so the pipeline behind the bank never sees a frame that is half old settings and half new. The active copy drives the block's outputs. It takes the pending values only when a vertical-blanking pulse arrives, and the commit policy decides which pulses count.

After reset the bank runs in automatic mode: every blanking pulse copies the pending set into the active set. Software can turn automatic mode off through a control register. After that, a copy happens only at the first blanking pulse that follows a commit request. The request bit reads back as busy until the copy has taken place. Software polls it, and starts the next batch of writes once it has dropped.

Top module: `shadow_commit_regs`

## Requirements
- R1: After reset, every active word is zero, every pending word reads zero, and the control register reads zero (automatic mode, not busy).
- R2: A write to byte address CFG_BASE+4*i (i below NUM_REGS) changes pending word i, which reads back at once. Active word i keeps its value until a copy takes place.
- R3: In automatic mode (control bit 0 = 0), every cycle with `vblank` high copies all pending words into the active words at that clock edge.
- R4: In automatic mode, a commit request (control bit 1 written as 1) is ignored: `load_busy` stays low and bit 1 reads 0. Writing bit 0 as 0 cancels any outstanding request.
- R5: In manual mode (control bit 0 = 1), a `vblank` with no outstanding request leaves the active words unchanged.
- R6: In manual mode, writing control bit 1 as 1 sets `load_busy`. The busy flag stays set through cycles without `vblank`. At the next `vblank` edge the pending words are copied and the flag clears.
- R7: A pending-word write in the same cycle as a copy does not reach the active word in that copy. The active word takes the previous pending value, and the new value stays pending.
- R8: Reads of addresses that map to neither the control register nor a configuration word return zero. Writes to such addresses change nothing.
- R9: The control register at byte address CTRL_ADDR reads bit 0 as the manual-mode flag and bit 1 as busy. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| vblank | input | 1 | Vertical-blanking pulse, sampled at each clock edge |
| active_cfg | output | NUM_REGS*DATA_W | Active words, word i at bits [i*DATA_W +: DATA_W] |
| load_busy | output | 1 | Commit request outstanding |
| manual_mode | output | 1 | Automatic copying is disabled |

## Verification
The bench targets the cycle where a configuration write and a copy happen together. A design that let the write pass straight through would show the new value in the active word one frame early. It also sets a commit request in automatic mode. If the request stuck there, the busy flag would stay set and software would wait on it for ever. A blanking pulse in manual mode with no request is checked too: a design that ignored the mode would copy the pending set anyway. Random mixes of writes to the control register, configuration words and unmapped addresses run against a model of pending, active and busy state. This exposes a busy flag that clears at the wrong edge, and address decoding that aliases into the window.

// File: rtl/shadow_cmt_pkg.sv
package shadow_cmt_pkg;
   localparam int CTL_MANUAL_BIT = 0;
   localparam int CTL_BUSY_BIT   = 1;
   localparam int MAP_LIMIT      = 'h5800;
   localparam int CFG_WIN_LO     = 'h0800;
   localparam int CFG_WIN_HI     = 'h1000;
endpackage

// File: rtl/shcm_decode.sv
module shcm_decode #(
   parameter int ADDR_W    = 15,
   parameter int NUM_REGS  = 8,
   parameter int CFG_BASE  = 'h800,
   parameter int CTRL_ADDR = 'h040
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] cfg_sel,
   output logic                ctrl_hit
);
   localparam int WORD_W  = ADDR_W - 2;
   localparam int CFG_W0  = CFG_BASE / 4;
   localparam int CTRL_W  = CTRL_ADDR / 4;

   logic [WORD_W-1:0] word;
   logic [1:0]        unused_lo;

   assign word      = addr[ADDR_W-1:2];
   assign unused_lo = addr[1:0];
   assign ctrl_hit  = (word == WORD_W'(CTRL_W));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign cfg_sel[i] = (word == WORD_W'(CFG_W0 + i));
   end

   // R8
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_sel, ctrl_hit}));
endmodule

// File: rtl/shcm_ctrl.sv
module shcm_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [1:0] ctl_wdata,
   input  logic       vblank,
   output logic       copy_en,
   output logic       manual_q,
   output logic       busy_q
);
   import shadow_cmt_pkg::*;

   assign copy_en = vblank & (~manual_q | busy_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         manual_q <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         if (copy_en)
            busy_q <= 1'b0;
         if (ctl_wr) begin
            manual_q <= ctl_wdata[CTL_MANUAL_BIT];
            if (!ctl_wdata[CTL_MANUAL_BIT])
               busy_q <= 1'b0;
            else if (ctl_wdata[CTL_BUSY_BIT])
               busy_q <= 1'b1;
         end
      end
   end

   // R4
   auto_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !manual_q |-> !busy_q);

   // R6
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(vblank) || !manual_q));

   // R6
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(ctl_wr && ctl_wdata[CTL_BUSY_BIT]));
endmodule

// File: rtl/shcm_slot.sv
module shcm_slot #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              copy_en,
   output logic [DATA_W-1:0] pend_q,
   output logic [DATA_W-1:0] act_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (copy_en)
            act_q <= pend_q;
         if (wr_en)
            pend_q <= wdata;
      end
   end

   // R2
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q) |-> $past(copy_en));

   // R7
   copy_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(copy_en && wr_en) |-> (act_q != pend_q || $past(pend_q) == $past(wdata)));
endmodule

// File: rtl/shadow_commit_regs.sv
module shadow_commit_regs #(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 8,
   parameter int CFG_BASE  = 'h800,
   parameter int CTRL_ADDR = 'h040
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic                         vblank,
   output logic [NUM_REGS*DATA_W-1:0]   active_cfg,
   output logic                         load_busy,
   output logic                         manual_mode
);
   import shadow_cmt_pkg::*;

   localparam int CFG_END = CFG_BASE + 4 * NUM_REGS;

   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must hold the two control bits");
   end
   if (NUM_REGS < 1) begin : g_bad_n
      $error("NUM_REGS must be at least one");
   end
   if ((CFG_BASE % 4) != 0 || (CTRL_ADDR % 4) != 0) begin : g_bad_al
      $error("addresses must be word aligned");
   end
   if (CFG_BASE < CFG_WIN_LO || CFG_END > CFG_WIN_HI) begin : g_bad_win
      $error("configuration words must sit inside the layer window");
   end
   if (CTRL_ADDR >= CFG_BASE && CTRL_ADDR < CFG_END) begin : g_bad_ov
      $error("control register overlaps configuration words");
   end
   if ((1 << ADDR_W) < MAP_LIMIT || CTRL_ADDR >= MAP_LIMIT) begin : g_bad_map
      $error("address width or control address outside the map");
   end

   logic [NUM_REGS-1:0] cfg_sel;
   logic                ctrl_hit;
   logic                copy_en;
   logic [DATA_W-1:0]   pend [NUM_REGS];

   shcm_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .CFG_BASE (CFG_BASE),
      .CTRL_ADDR(CTRL_ADDR)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .cfg_sel (cfg_sel),
      .ctrl_hit(ctrl_hit)
   );

   shcm_ctrl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (bus_wr & ctrl_hit),
      .ctl_wdata(bus_wdata[1:0]),
      .vblank   (vblank),
      .copy_en  (copy_en),
      .manual_q (manual_mode),
      .busy_q   (load_busy)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      shcm_slot #(.DATA_W(DATA_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (bus_wr & cfg_sel[i]),
         .wdata  (bus_wdata),
         .copy_en(copy_en),
         .pend_q (pend[i]),
         .act_q  (active_cfg[i*DATA_W +: DATA_W])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (ctrl_hit) begin
         bus_rdata[CTL_MANUAL_BIT] = manual_mode;
         bus_rdata[CTL_BUSY_BIT]   = load_busy;
      end
      for (int i = 0; i < NUM_REGS; i++)
         if (cfg_sel[i])
            bus_rdata = pend[i];
   end

   // R3
   auto_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(vblank && !manual_mode) |-> active_cfg[DATA_W-1:0] == $past(pend[0]));

   // R5
   manual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(vblank && manual_mode && !load_busy) |-> $stable(active_cfg));
endmodule

// File: tb/shadow_commit_regs_tb.sv
module shadow_commit_regs_tb_top;
   localparam int CLK_NS = 10;
   localparam int AW = 15;
   localparam int DW = 32;
   localparam int NR = 8;
   localparam int CFGB = 'h800;
   localparam int CTLA = 'h040;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic vblank = 1'b0;
   logic [NR*DW-1:0] active_cfg;
   logic load_busy, manual_mode;

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] m_pend [NR];
   logic [DW-1:0] m_act  [NR];
   logic m_man = 1'b0, m_busy = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   shadow_commit_regs #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR),
      .CFG_BASE(CFGB), .CTRL_ADDR(CTLA)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vblank(vblank),
      .active_cfg(active_cfg), .load_busy(load_busy), .manual_mode(manual_mode));

   task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [DW-1:0] model_rd(logic [AW-1:0] a);
      int w = int'(a) / 4;
      if (w == CTLA / 4) return {30'b0, m_busy, m_man};
      if (w >= CFGB / 4 && w < CFGB / 4 + NR) return m_pend[w - CFGB / 4];
      return '0;
   endfunction

   task automatic check_outs(string tag);
      for (int i = 0; i < NR; i++)
         check({tag, " active"}, active_cfg[i*DW +: DW], m_act[i]);
      check({tag, " busy"}, {31'b0, load_busy}, {31'b0, m_busy});
   endtask

   task automatic read_chk(logic [AW-1:0] a, string tag);
      @(negedge clk);
      bus_wr = 1'b0; vblank = 1'b0; bus_addr = a;
      #1 check({tag, " read"}, bus_rdata, model_rd(a));
   endtask

   task automatic step(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic vb, string tag);
      logic cp;
      int w;
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; vblank = vb;
      @(posedge clk);
      cp = vb && (!m_man || m_busy);
      if (cp) for (int i = 0; i < NR; i++) m_act[i] = m_pend[i];
      if (cp) m_busy = 1'b0;
      w = int'(a) / 4;
      if (wr && w >= CFGB / 4 && w < CFGB / 4 + NR) m_pend[w - CFGB / 4] = d;
      if (wr && w == CTLA / 4) begin
         m_man = d[0];
         if (!d[0]) m_busy = 1'b0;
         else if (d[1]) m_busy = 1'b1;
      end
      #1 check_outs(tag);
      @(negedge clk);
      bus_wr = 1'b0; vblank = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [AW-1:0] ra;
      int sel;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NR; i++) begin m_pend[i] = '0; m_act[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1 check_outs("R1");
      read_chk(AW'(CTLA), "R1 ctrl");
      read_chk(AW'(CFGB), "R1 cfg0");

      step(1, AW'(CFGB), 32'hA5A5_0001, 0, "R2 write");
      read_chk(AW'(CFGB), "R2 readback");
      step(0, '0, '0, 1, "R3 auto copy");

      step(1, AW'(CTLA), 32'h2, 0, "R4 load in auto");
      read_chk(AW'(CTLA), "R4 ctrl");

      step(1, AW'(CTLA), 32'h1, 0, "R5 manual on");
      step(1, AW'(CFGB + 4), 32'hB0B0_0002, 0, "R5 write");
      step(0, '0, '0, 1, "R5 idle vblank");

      step(1, AW'(CTLA), 32'h3, 0, "R6 request");
      read_chk(AW'(CTLA), "R9 busy readback");
      step(0, '0, '0, 0, "R6 hold");
      step(0, '0, '0, 1, "R6 commit");
      read_chk(AW'(CTLA), "R6 ctrl after");

      step(1, AW'(CFGB + 4), 32'hD0D0_0004, 0, "R7 prep");
      step(1, AW'(CTLA), 32'h3, 0, "R7 request");
      step(1, AW'(CFGB + 4), 32'hE0E0_0005, 1, "R7 same cycle");
      read_chk(AW'(CFGB + 4), "R7 pending");

      step(1, AW'('h1000), 32'hDEAD_BEEF, 0, "R8 unmapped write");
      read_chk(AW'('h1000), "R8 unmapped read");
      for (int i = 0; i < NR; i++) read_chk(AW'(CFGB + 4*i), "R8 cfg intact");
      step(1, AW'(CTLA), 32'hFFFF_FFFF, 0, "R9 all ones");
      read_chk(AW'(CTLA), "R9 ctrl bits");
      step(1, AW'(CTLA), 32'h0, 0, "R4 cancel");
      read_chk(AW'(CTLA), "R4 cancel read");

      for (int n = 0; n < 3000; n++) begin
         sel = $urandom_range(0, 99);
         if (sel < 70) ra = AW'(CFGB + 4 * $urandom_range(0, NR - 1));
         else if (sel < 85) ra = AW'(CTLA);
         else ra = AW'($urandom_range(0, 'h57FF)) & ~AW'(3);
         step($urandom_range(0, 2) != 0, ra, $urandom(),
              $urandom_range(0, 6) == 0, "R3 R6 R7 random");
         if (n % 4 == 0) read_chk(ra, "R2 R8 R9 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule